// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream on one serial data line, framed by an external bit clock and a frame clock. All three lines are oversampled in the system clock domain. A rising bit-clock edge is the moment a data bit is taken. The receiver supports three framings: left-justified, right-justified, and the common two-channel format in which the frame clock leads the data by one bit. It accepts words of 16, 20 or 24 bits and bit-clock ratios of 32, 48 or 64 times the frame rate.

Each received word is sign-extended to 24 bits and presented on the left or right output together with a single-cycle valid strobe. Framing, word length and ratio are static inputs. They may change only while reset is held. A combination that cannot fit a word into its slot, or that uses a reserved code, raises a configuration-error flag, and while the flag is up the receiver delivers nothing.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low and in the first cycle after it, both samples read zero and both valid strobes are low.
- R2: Left-justified framing (format code 0): the MSB is the first bit taken after a frame-clock transition, and a high frame clock marks the left channel.
- R3: Two-channel delayed framing (format code 2): the MSB is the second bit taken after a frame-clock transition, a low frame clock marks the left channel, and a word that fills its whole slot ends on the first bit of the next frame-clock level.
- R4: Right-justified framing (format code 1): the LSB is the last bit of the slot, so the word starts at slot position (slot length minus word length).
- R5: Word length code 0, 1 or 2 selects 16, 20 or 24 bits, received MSB first. Each word is sign-extended from its top bit to 24 bits.
- R6: Ratio code 0, 1 or 2 selects 32, 48 or 64 bit clocks per frame, which gives slots of 16, 24 or 32 bits.
- R7: Slot bits outside the word have no effect on the delivered samples.
- R8: Each valid strobe is one system-clock cycle wide. The two strobes never rise together, and every completed word produces exactly one strobe.
- R9: A word length longer than the slot, or a format, length or ratio code of 3, drives the configuration-error output high, and no strobe is issued while it stays high.
- R10: After reset, no word is delivered from a slot whose opening frame-clock transition was not observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 delayed two-channel |
| cfg_wlen | input | 2 | Word length: 0 = 16, 1 = 20, 2 = 24 bits |
| cfg_ratio | input | 2 | Bit clocks per frame: 0 = 32, 1 = 48, 2 = 64 |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Frame clock, one period per stereo pair |
| sdata | input | 1 | Serial data, MSB first |
| left_sample | output | 24 | Last left word, sign-extended |
| left_valid | output | 1 | One-cycle strobe for a new left word |
| right_sample | output | 24 | Last right word, sign-extended |
| right_valid | output | 1 | One-cycle strobe for a new right word |
| cfg_error | output | 1 | Configuration cannot be received |

## Verification
The hardest case to reach is the delayed framing with a word that fills its slot. There, the LSB of each word is clocked in while the frame clock already shows the other channel, so the channel decision must come from the frame-clock level seen one bit earlier. The stimulus reaches this case by streaming 16-bit words at 32 bit clocks per frame in that framing. The bench builds the frame clock one bit ahead of the channel that owns each data bit. Every word is checked, including extreme positive and negative values, and so is the dropping of the partial first slot after reset.

// File: rtl/sar_pkg.sv
// Shared encodings and helpers for the serial audio receiver.
// Assumes the caller supplies 2-bit configuration codes; code 3 is reserved everywhere.
package sar_pkg;
    localparam int OUT_W = 24;
    localparam int CNT_W = 6;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_RJ  = 2'd1,
        FMT_DLY = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    // Bits per channel slot for a ratio code; zero for the reserved code.
    function automatic logic [CNT_W-1:0] slot_bits(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(16);
            2'd1:    return CNT_W'(24);
            2'd2:    return CNT_W'(32);
            default: return '0;
        endcase
    endfunction

    // Bits per word for a length code; zero for the reserved code.
    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(16);
            2'd1:    return CNT_W'(20);
            2'd2:    return CNT_W'(24);
            default: return '0;
        endcase
    endfunction

    // True when the configuration cannot be received.
    function automatic logic cfg_bad(input logic [1:0] f, input logic [1:0] w,
                                     input logic [1:0] r);
        return (f == 2'd3) || (w == 2'd3) || (r == 2'd3) ||
               (word_bits(w) > slot_bits(r));
    endfunction

    // Sign-extend the low bits of a shifted word to the output width.
    function automatic logic [OUT_W-1:0] sext(input logic [OUT_W-1:0] v,
                                              input logic [1:0] w);
        case (w)
            2'd0:    return {{(OUT_W-16){v[15]}}, v[15:0]};
            2'd1:    return {{(OUT_W-20){v[19]}}, v[19:0]};
            default: return v;
        endcase
    endfunction
endpackage

// File: rtl/sar_input_sampler.sv
// Brings the bit clock, frame clock and data into the system clock domain
// through SYNC_STAGES flops and flags each rising bit-clock edge.
// Assumes the system clock is at least four times the bit-clock rate.
// All three lines pass through equal delays, so they stay aligned.
module sar_input_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrclk,
    input  logic sdata,
    output logic bit_evt,
    output logic bit_lr,
    output logic bit_dat
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] b_pipe, l_pipe, d_pipe;
    logic         b_last;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            // Single capture stage for the three serial lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    b_pipe <= '0; l_pipe <= '0; d_pipe <= '0;
                end else begin
                    b_pipe <= bclk; l_pipe <= lrclk; d_pipe <= sdata;
                end
            end
        end else begin : g_chain
            // Multi-stage synchroniser chain for the three serial lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    b_pipe <= '0; l_pipe <= '0; d_pipe <= '0;
                end else begin
                    b_pipe <= {b_pipe[TOP-1:0], bclk};
                    l_pipe <= {l_pipe[TOP-1:0], lrclk};
                    d_pipe <= {d_pipe[TOP-1:0], sdata};
                end
            end
        end
    endgenerate

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) b_last <= 1'b0;
        else        b_last <= b_pipe[TOP];
    end

    assign bit_evt = b_pipe[TOP] & ~b_last;
    assign bit_lr  = l_pipe[TOP];
    assign bit_dat = d_pipe[TOP];
endmodule

// File: rtl/sar_slot_tracker.sv
// Tracks the bit position inside the current channel slot.
// In the delayed framing the frame clock is viewed one bit late, so every
// framing sees its MSB at position 0. The tracker locks on the first
// transition seen after two bits of history, which discards the partial
// slot that follows reset.
module sar_slot_tracker #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_evt,
    input  logic             bit_lr,
    input  logic             is_dly,
    output logic [CNT_W-1:0] idx,
    output logic             left_ch,
    output logic             active
);
    logic             lr_h1, lr_h2;
    logic [1:0]       hist;
    logic [CNT_W-1:0] cnt;
    logic             locked;
    logic             eff, eff_prev, trans;

    assign eff      = is_dly ? lr_h1 : bit_lr;
    assign eff_prev = is_dly ? lr_h2 : lr_h1;
    assign trans    = bit_evt && (hist == 2'd2) && (eff != eff_prev);
    assign idx      = trans ? '0 : ((&cnt) ? cnt : cnt + 1'b1);
    assign active   = locked | trans;
    assign left_ch  = is_dly ? ~eff : eff;

    // Update frame-clock history, slot counter and lock on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_h1  <= 1'b0;
            lr_h2  <= 1'b0;
            hist   <= 2'd0;
            cnt    <= '1;
            locked <= 1'b0;
        end else if (bit_evt) begin
            lr_h1  <= bit_lr;
            lr_h2  <= lr_h1;
            hist   <= (hist == 2'd2) ? hist : hist + 2'd1;
            cnt    <= idx;
            locked <= locked | trans;
        end
    end

    a_r10_parked_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (&cnt));
endmodule

// File: rtl/sar_word_capture.sv
// Shifts in the bits that fall inside the word window of a slot. When the
// last bit arrives, the word is sign-extended and published on the owning
// channel with a one-cycle strobe. The window starts at 0, or at
// (slot - word) for right-justified data.
module sar_word_capture
    import sar_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_evt,
    input  logic             bit_dat,
    input  logic             active,
    input  logic             left_ch,
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] slot_len,
    input  logic [CNT_W-1:0] word_len,
    input  logic [1:0]       wlen_code,
    input  logic             is_rj,
    input  logic             cfg_err,
    output logic [OUT_W-1:0] left_sample,
    output logic             left_valid,
    output logic [OUT_W-1:0] right_sample,
    output logic             right_valid
);
    logic [CNT_W-1:0] start, stop;
    logic [OUT_W-1:0] sh, nxt;
    logic             in_word, last;

    assign start   = is_rj ? slot_len - word_len : '0;
    assign stop    = start + word_len - 1'b1;
    assign in_word = bit_evt && active && !cfg_err && (idx >= start) &&
                     (idx <= stop) && (idx < slot_len);
    assign last    = in_word && (idx == stop);
    assign nxt     = {sh[OUT_W-2:0], bit_dat};

    // Shift register collecting the word bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh <= '0;
        else if (in_word) sh <= nxt;
    end

    // Publish a completed word on its channel with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_sample  <= '0;
            right_sample <= '0;
            left_valid   <= 1'b0;
            right_valid  <= 1'b0;
        end else begin
            left_valid  <= 1'b0;
            right_valid <= 1'b0;
            if (last) begin
                if (left_ch) begin
                    left_sample <= sext(nxt, wlen_code);
                    left_valid  <= 1'b1;
                end else begin
                    right_sample <= sext(nxt, wlen_code);
                    right_valid  <= 1'b1;
                end
            end
        end
    end

    a_r8_left_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |=> !left_valid);
    a_r8_right_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |=> !right_valid);
    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_valid && right_valid));
    a_r9_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> (!left_valid && !right_valid));
endmodule

// File: rtl/serial_audio_rx.sv
// Stereo serial audio receiver top level: sampler, slot tracker and word
// capture. It also decodes the static configuration into slot and word
// lengths and the error flag. Configuration may change only under reset.
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_fmt,
    input  logic [1:0]  cfg_wlen,
    input  logic [1:0]  cfg_ratio,
    input  logic        bclk,
    input  logic        lrclk,
    input  logic        sdata,
    output logic [23:0] left_sample,
    output logic        left_valid,
    output logic [23:0] right_sample,
    output logic        right_valid,
    output logic        cfg_error
);
    logic             bit_evt, bit_lr, bit_dat;
    logic [CNT_W-1:0] trk_idx, slot_len, word_len;
    logic             trk_left, trk_active, is_dly, is_rj;

    assign slot_len  = slot_bits(cfg_ratio);
    assign word_len  = word_bits(cfg_wlen);
    assign is_dly    = (fmt_e'(cfg_fmt) == FMT_DLY);
    assign is_rj     = (fmt_e'(cfg_fmt) == FMT_RJ);
    assign cfg_error = cfg_bad(cfg_fmt, cfg_wlen, cfg_ratio);

    sar_input_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .bit_evt(bit_evt), .bit_lr(bit_lr), .bit_dat(bit_dat)
    );

    sar_slot_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_lr(bit_lr),
        .is_dly(is_dly), .idx(trk_idx), .left_ch(trk_left), .active(trk_active)
    );

    sar_word_capture #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_dat(bit_dat),
        .active(trk_active), .left_ch(trk_left), .idx(trk_idx),
        .slot_len(slot_len), .word_len(word_len), .wlen_code(cfg_wlen),
        .is_rj(is_rj), .cfg_err(cfg_error),
        .left_sample(left_sample), .left_valid(left_valid),
        .right_sample(right_sample), .right_valid(right_valid)
    );

    a_r6_word_inside_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid || right_valid) |-> ($past(trk_idx) < $past(slot_len)));
    a_r5_sign_ext_16: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid && cfg_wlen == 2'd0 && $past(cfg_wlen) == 2'd0) |->
        (left_sample[23:15] == 9'h000 || left_sample[23:15] == 9'h1FF));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!left_valid && !right_valid));
endmodule

// File: tb/serial_audio_rx_tb.sv
// Directed bench: each task configures, resets, streams frames and checks.
module serial_audio_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0, cfg_wlen = 2'd0, cfg_ratio = 2'd0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [23:0] left_sample, right_sample;
    logic        left_valid, right_valid, cfg_error;

    always #2 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
        .cfg_ratio(cfg_ratio), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .left_sample(left_sample), .left_valid(left_valid),
        .right_sample(right_sample), .right_valid(right_valid),
        .cfg_error(cfg_error)
    );

    int n_chk = 0, n_bad = 0, pulse_err = 0;
    bit finished = 0;
    logic [24:0] got_q[$];
    logic [24:0] exp_q[$];
    logic lv_d = 1'b0, rv_d = 1'b0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    // Collect delivered words and count strobe shape violations (R8).
    always @(negedge clk) begin
        if (left_valid)  got_q.push_back({1'b1, left_sample});
        if (right_valid) got_q.push_back({1'b0, right_sample});
        if (left_valid && right_valid) pulse_err++;
        if ((left_valid && lv_d) || (right_valid && rv_d)) pulse_err++;
        lv_d = left_valid;
        rv_d = right_valid;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    task automatic do_reset(input logic [1:0] f, input logic [1:0] w,
                            input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
        cfg_fmt = f; cfg_wlen = w; cfg_ratio = r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        got_q.delete(); exp_q.delete(); pulse_err = 0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset(2'd0, 2'd0, 2'd0);
        check(left_sample == 24'h0 && right_sample == 24'h0, "R1", "samples after reset",
              {8'h0, left_sample}, 32'h0);
        check(!left_valid && !right_valid, "R1", "strobes after reset",
              {30'h0, left_valid, right_valid}, 32'h0);
        check(cfg_error == 1'b0, "R9", "no error for 16b/32fs", {31'h0, cfg_error}, 32'h0);
    endtask

    // Stream NF frames in the given configuration and check every word.
    task automatic t_stream(input logic [1:0] f, input logic [1:0] w,
                            input logic [1:0] r, input bit want_err, input string req);
        int S, W, NF;
        logic [23:0] words[6];
        bit dq[$];
        bit chq[$];
        S  = (r == 2'd0) ? 16 : (r == 2'd1) ? 24 : 32;
        W  = (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : 24;
        NF = 3;
        if (W > S) W = S;
        do_reset(f, w, r);
        check(cfg_error == want_err, "R9", "config error flag", {31'h0, cfg_error},
              {31'h0, want_err});
        for (int k = 0; k < 2 * NF; k++) begin
            words[k] = rnd() & ((24'h1 << W) - 1);
        end
        words[1] = 24'h1 << (W - 1);            // most negative
        words[2] = (24'h1 << (W - 1)) - 1;      // most positive
        for (int k = 0; k < 2 * NF; k++) begin
            for (int p = 0; p < S; p++) begin
                bit b;
                int pos;
                pos = (f == 2'd1) ? p - (S - W) : p;
                if (pos >= 0 && pos < W) b = words[k][W-1-pos];
                else                     b = rnd() & 1;   // R7 filler
                dq.push_back(b);
                chq.push_back((k % 2) == 0);
            end
        end
        for (int i = 0; i < dq.size(); i++) begin
            bit nch;
            nch = (i + 1 < chq.size()) ? chq[i+1] : chq[i];
            @(negedge clk);
            bclk  = 1'b0;
            sdata = dq[i];
            lrclk = (f == 2'd2) ? ~nch : chq[i];
            repeat (2) @(negedge clk);
            bclk = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        bclk = 1'b0;
        repeat (20) @(negedge clk);
        if (!want_err) begin
            for (int k = 1; k < 2 * NF; k++) begin
                logic signed [23:0] t;
                t = words[k] << (24 - W);
                t = t >>> (24 - W);
                exp_q.push_back({(k % 2) == 0, t});
            end
        end
        // R10: the partial first slot is dropped, so the count is exact.
        check(got_q.size() == exp_q.size(), "R10", "delivered word count",
              got_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++) begin
            check(got_q[k] === exp_q[k], req, "word value (bit24 = left)",
                  {7'h0, got_q[k]}, {7'h0, exp_q[k]});
        end
        check(pulse_err == 0, "R8", "strobe shape", pulse_err, 0);
    endtask

    initial begin
        t_reset();
        t_stream(2'd0, 2'd2, 2'd2, 1'b0, "R2 R5 R6 R7");  // left-justified 24b/64fs
        t_stream(2'd0, 2'd0, 2'd0, 1'b0, "R2 R6");        // left-justified 16b/32fs
        t_stream(2'd2, 2'd0, 2'd0, 1'b0, "R3");           // delayed, word fills slot
        t_stream(2'd2, 2'd2, 2'd1, 1'b0, "R3 R6");        // delayed 24b/48fs
        t_stream(2'd2, 2'd1, 2'd2, 1'b0, "R3 R5 R7");     // delayed 20b/64fs
        t_stream(2'd1, 2'd0, 2'd2, 1'b0, "R4 R7");        // right-justified 16b/64fs
        t_stream(2'd1, 2'd1, 2'd1, 1'b0, "R4 R5");        // right-justified 20b/48fs
        t_stream(2'd1, 2'd2, 2'd1, 1'b0, "R4 R6");        // right-justified 24b/48fs
        t_stream(2'd0, 2'd2, 2'd0, 1'b1, "R9");           // 24b in 16-bit slot
        t_stream(2'd3, 2'd0, 2'd2, 1'b1, "R9");           // reserved format code
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule